// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block holds the interrupt logic for one bank of general-purpose input pins. Each pin has a two-bit trigger selector. The selector picks rising-edge, falling-edge or both-edge detection on the already-filtered pin value, or turns detection off. Level sensing is not offered. When a pin shows an enabled edge, the block latches a sticky pending bit. Software acknowledges that bit by writing a one to it.

A per-pin mask decides which pending bits may raise the single bank interrupt line. The mask has no plain read-write port. Software changes it through two write-one ports: one port sets mask bits and the other clears them. A pin's pending bit records edges whether or not the pin is masked. A small register decoder sits on a simple word bus and places the bank's registers according to its bank number. Reads return data one cycle after the read strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1, every trigger selector is 0, and irq_out and bus_rdata are 0.
- R2: Pin p's trigger selector is bits 4:3 of the word at 0x100 + 4·(BANK_ID·NUM_PINS + p). Its codes are: 0 = off, 1 = rising, 2 = falling, 3 = both. A read of this word returns the selector in bits 4:3 and zeros in every other bit.
- R3: An enabled edge on a pin, seen between two consecutive clock samples, sets that pin's pending bit at the second sample. The bit stays set until software clears it.
- R4: Writing to the pending word at 0x80 + 4·BANK_ID clears each pending bit whose data bit is 1. Bits written as 0 keep their value. A read of this word returns the pending bits.
- R5: If an enabled edge and a write-one clear of the same pending bit happen in the same cycle, the bit stays set.
- R6: Writing to the mask-set word at 0xA0 + 4·BANK_ID sets each mask bit whose data bit is 1 and leaves the others unchanged. A read of this word returns the mask.
- R7: Writing to the mask-clear word at 0xC0 + 4·BANK_ID clears each mask bit whose data bit is 1 and leaves the others unchanged. A read of this word also returns the mask.
- R8: irq_out is registered. In each cycle it equals the OR, taken one cycle earlier, of the pending bits whose mask bit is 0.
- R9: A masked pin still records its edges in its pending bit, and that pending bit does not drive irq_out.
- R10: Writes to any address that is not one of this bank's registers change nothing, including the register addresses of other banks. Reads of such addresses return 0.
- R11: bus_rdata loads only in the cycle after a read strobe and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| pin_in | input | NUM_PINS | Filtered pin levels, synchronous to clk |
| irq_out | output | 1 | Bank interrupt, registered |

## Verification
The bench builds the block with BANK_ID = 2 and a full bank of 32 pins. With BANK_ID = 2, the control words sit at a non-zero offset, so the decoder's bank arithmetic is exercised. It also lets the bench write to the addresses that bank 0 would use and confirm that they do nothing. With 32 pins, the pin count fills the data word, so the trigger codes can be spread as p mod 4 and every code is active on eight pins at once. The boundary bits 0 and 31 then reach the pending, mask and interrupt paths.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Edge selector codes held per pin
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_e;

  // Bit position of the selector inside a control word
  localparam int unsigned TRIG_LSB = 3;

  // Register bases; each bank steps by one word
  localparam int unsigned PEND_BASE = 32'h080;
  localparam int unsigned MSET_BASE = 32'h0A0;
  localparam int unsigned MCLR_BASE = 32'h0C0;
  localparam int unsigned CTL_BASE  = 32'h100;

  typedef struct packed {
    logic pend;
    logic mset;
    logic mclr;
    logic ctl;
  } reg_hit_t;

endpackage

// File: rtl/gpio_irq_regdec.sv
module gpio_irq_regdec
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned PEND_A = PEND_BASE + 4 * BANK_ID;
  localparam int unsigned MSET_A = MSET_BASE + 4 * BANK_ID;
  localparam int unsigned MCLR_A = MCLR_BASE + 4 * BANK_ID;
  localparam int unsigned CTL_LO = CTL_BASE + 4 * BANK_ID * NUM_PINS;
  localparam int unsigned CTL_HI = CTL_LO + 4 * NUM_PINS;

  logic [31:0] a32;
  logic [31:0] off;
  logic        unused_off;

  assign a32 = 32'(addr);
  assign off = a32 - CTL_LO;

  always_comb begin
    hit      = '0;
    hit.pend = (a32 == PEND_A);
    hit.mset = (a32 == MSET_A);
    hit.mclr = (a32 == MCLR_A);
    hit.ctl  = (a32 >= CTL_LO) && (a32 < CTL_HI) && (addr[1:0] == 2'b00);
  end

  assign idx        = off[IDX_W+1:2];
  assign unused_off = ^{off[31:IDX_W+2], off[1:0]};

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [1:0]          cfg_trig,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [1:0]          rd_trig,
  output logic [NUM_PINS-1:0] edge_hit
);

  trig_e               trig_q [NUM_PINS];
  logic [NUM_PINS-1:0] pin_q;

  // Previous sample follows the pin even in reset, so no false edge after it
  always_ff @(posedge clk) begin
    pin_q <= pin_in;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise_w;
    logic fall_w;
    logic rise_en;
    logic fall_en;

    always_ff @(posedge clk) begin
      if (rst) begin
        trig_q[g] <= TRIG_OFF;
      end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
        trig_q[g] <= trig_e'(cfg_trig);
      end
    end

    assign rise_w      = pin_in[g] & ~pin_q[g];
    assign fall_w      = ~pin_in[g] & pin_q[g];
    assign rise_en     = (trig_q[g] == TRIG_RISE) || (trig_q[g] == TRIG_ANY);
    assign fall_en     = (trig_q[g] == TRIG_FALL) || (trig_q[g] == TRIG_ANY);
    assign edge_hit[g] = (rise_w & rise_en) | (fall_w & fall_en);
  end

  assign rd_trig = trig_q[rd_idx];

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] edge_hit,
  input  logic                ack_we,
  input  logic                mset_we,
  input  logic                mclr_we,
  input  logic [NUM_PINS-1:0] wbits,
  output logic [NUM_PINS-1:0] pend_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic                irq_q
);

  logic [NUM_PINS-1:0] ack_bits;

  assign ack_bits = ack_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      // A fresh edge wins over an acknowledge in the same cycle
      pend_q <= (pend_q & ~ack_bits) | edge_hit;
      if (mset_we) begin
        mask_q <= mask_q | wbits;
      end else if (mclr_we) begin
        mask_q <= mask_q & ~wbits;
      end
      irq_q <= |(pend_q & ~mask_q);
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                irq_out
);

  localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  reg_hit_t            hit;
  logic [IDX_W-1:0]    idx;
  logic [1:0]          rd_trig;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] mask_q;
  logic                irq_q;
  logic [DATA_W-1:0]   rd_next;
  logic [DATA_W-1:0]   rdata_q;

  gpio_irq_regdec #(
    .NUM_PINS(NUM_PINS), .BANK_ID(BANK_ID), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  gpio_irq_edge #(
    .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)
  ) u_edge (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .cfg_we(bus_wr_en && hit.ctl), .cfg_idx(idx),
    .cfg_trig(bus_wdata[TRIG_LSB+1:TRIG_LSB]),
    .rd_idx(idx), .rd_trig(rd_trig), .edge_hit(edge_hit)
  );

  gpio_irq_stat #(
    .NUM_PINS(NUM_PINS)
  ) u_stat (
    .clk(clk), .rst(rst), .edge_hit(edge_hit),
    .ack_we(bus_wr_en && hit.pend),
    .mset_we(bus_wr_en && hit.mset),
    .mclr_we(bus_wr_en && hit.mclr),
    .wbits(bus_wdata[NUM_PINS-1:0]),
    .pend_q(status_q), .mask_q(mask_q), .irq_q(irq_q)
  );

  always_comb begin
    rd_next = '0;
    if (hit.pend) begin
      rd_next[NUM_PINS-1:0] = status_q;
    end else if (hit.mset || hit.mclr) begin
      rd_next[NUM_PINS-1:0] = mask_q;
    end else if (hit.ctl) begin
      rd_next[TRIG_LSB+1:TRIG_LSB] = rd_trig;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd_en) begin
      rdata_q <= rd_next;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] mask_q
);

  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_BASE + 4 * BANK_ID);
  localparam logic [ADDR_W-1:0] MSET_A = ADDR_W'(MSET_BASE + 4 * BANK_ID);
  localparam logic [ADDR_W-1:0] MCLR_A = ADDR_W'(MCLR_BASE + 4 * BANK_ID);

  logic                wr_pend;
  logic                wr_mset;
  logic                wr_mclr;
  logic [NUM_PINS-1:0] wbits;

  assign wr_pend = bus_wr_en && (bus_addr == PEND_A);
  assign wr_mset = bus_wr_en && (bus_addr == MSET_A);
  assign wr_mclr = bus_wr_en && (bus_addr == MCLR_A);
  assign wbits   = bus_wdata[NUM_PINS-1:0];

  // R1: state leaving reset
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status_q == '0) && (mask_q == '1) && !irq_out);

  // R3: pending bits only fall through an acknowledge write
  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_pend |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6: mask-set write raises the written bits
  assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
    wr_mset |=> ((mask_q & $past(wbits)) == $past(wbits)));

  // R7: mask-clear write drops the written bits
  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
    wr_mclr |=> ((mask_q & $past(wbits)) == '0));

  // R8: interrupt follows unmasked pending bits one cycle later
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(status_q & ~mask_q))));

  // R10: other writes leave the mask alone
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_mset || wr_mclr) |=> $stable(mask_q));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS(NUM_PINS), .BANK_ID(BANK_ID), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

  localparam int NP   = 32;
  localparam int BANK = 2;
  localparam int AW   = 12;
  localparam logic [AW-1:0] PEND = 12'h088;
  localparam logic [AW-1:0] MSET = 12'h0A8;
  localparam logic [AW-1:0] MCLR = 12'h0C8;
  localparam int CTL0 = 32'h200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic          irq;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP), .BANK_ID(BANK), .ADDR_W(AW), .DATA_W(32)) i_gpio_irq_bank (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins), .irq_out(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  bit    started = 0;
  string cur_tag = "R1";

  // Behavioural reference
  logic [31:0] m_st, m_mk, m_prev, m_rd, m_ed;
  logic        m_irq, m_irq_n;
  int          m_trig [NP];

  function automatic logic [AW-1:0] ctl_a(int p);
    return AW'(CTL0 + 4 * p);
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    int ai = int'(a);
    if (a == PEND) return m_st;
    if (a == MSET || a == MCLR) return m_mk;
    if (ai >= CTL0 && ai < CTL0 + 4 * NP && ai % 4 == 0)
      return 32'(m_trig[(ai - CTL0) / 4]) << 3;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = '0; m_mk = '1; m_irq = 1'b0; m_rd = '0; m_prev = pins;
      for (int p = 0; p < NP; p++) m_trig[p] = 0;
    end else begin
      m_ed = '0;
      for (int p = 0; p < NP; p++) begin
        case (m_trig[p])
          1: m_ed[p] = pins[p] & ~m_prev[p];
          2: m_ed[p] = ~pins[p] & m_prev[p];
          3: m_ed[p] = pins[p] ^ m_prev[p];
          default: m_ed[p] = 1'b0;
        endcase
      end
      m_irq_n = |(m_st & ~m_mk);
      if (rd_en) m_rd = model_read(addr);
      if (wr_en) begin
        if (addr == PEND) m_st = m_st & ~wdata;
        else if (addr == MSET) m_mk = m_mk | wdata;
        else if (addr == MCLR) m_mk = m_mk & ~wdata;
        else if (int'(addr) >= CTL0 && int'(addr) < CTL0 + 4 * NP && addr[1:0] == 2'b00)
          m_trig[(int'(addr) - CTL0) / 4] = int'(wdata[4:3]);
      end
      m_st   = m_st | m_ed;
      m_irq  = m_irq_n;
      m_prev = pins;
    end
    started = 1;
  end

  // Clock-by-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL R8 (%s): irq_out actual %0b expected %0b", cur_tag, irq, m_irq);
      end
      n_cmp++;
      if (rdata !== m_rd) begin
        n_bad++;
        $display("FAIL R11 (%s): bus_rdata actual %h expected %h", cur_tag, rdata, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    cur_tag = tag;
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_expect(PEND, 32'h0, "R1");
    rd_expect(MSET, 32'hFFFF_FFFF, "R1");
    rd_expect(ctl_a(5), 32'h0, "R1");
    chk("R1", {31'b0, irq}, 32'h0);

    // R2 selectors p mod 4, with junk in other bits
    cur_tag = "R2";
    for (int p = 0; p < NP; p++) wr(ctl_a(p), 32'hFFFF_FFE7 | (32'(p % 4) << 3));
    rd_expect(ctl_a(6), 32'h10, "R2");
    rd_expect(ctl_a(7), 32'h18, "R2");
    rd_expect(ctl_a(31), 32'h18, "R2");

    // R9 all rise while masked: rising and both-edge pins latch
    @(negedge clk); pins = '1;
    rd_expect(PEND, 32'hAAAA_AAAA, "R9");
    chk("R9", {31'b0, irq}, 32'h0);

    // R3 all fall: falling and both-edge pins add, earlier bits stay
    @(negedge clk); pins = '0;
    rd_expect(PEND, 32'hEEEE_EEEE, "R3");

    // R7 unmask low four pins
    wr(MCLR, 32'h0000_000F);
    rd_expect(MCLR, 32'hFFFF_FFF0, "R7");
    @(negedge clk);
    chk("R8", {31'b0, irq}, 32'h1);

    // R4 acknowledge bits 1..3
    wr(PEND, 32'h0000_000E);
    rd_expect(PEND, 32'hEEEE_EEE0, "R4");
    @(negedge clk);
    chk("R8", {31'b0, irq}, 32'h0);

    // R5 edge on pin 3 together with its acknowledge
    cur_tag = "R5";
    @(negedge clk); pins[3] = 1'b1; wr_en = 1'b1; addr = PEND; wdata = 32'h8;
    @(negedge clk); wr_en = 1'b0;
    rd_expect(PEND, 32'hEEEE_EEE8, "R5");

    // R6 mask pin 3 again
    wr(MSET, 32'h0000_0008);
    rd_expect(MSET, 32'hFFFF_FFF8, "R6");
    @(negedge clk);
    chk("R6", {31'b0, irq}, 32'h0);

    // R10 bank 0 addresses and an unmapped one
    cur_tag = "R10";
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h0C0, 32'hFFFF_FFFF);
    wr(12'h100, 32'h18);
    wr(12'h3FC, 32'hFFFF_FFFF);
    rd_expect(MCLR, 32'hFFFF_FFF8, "R10");
    rd_expect(PEND, 32'hEEEE_EEE8, "R10");
    rd_expect(ctl_a(0), 32'h0, "R10");
    rd_expect(12'h0C0, 32'h0, "R10");

    // R11 read data holds without a strobe
    repeat (3) @(negedge clk);
    chk("R11", rdata, 32'h0);

    // R3 random traffic against the reference
    cur_tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      @(negedge clk);
      pins  = pins ^ ($urandom() & $urandom());
      sel   = int'($urandom_range(0, 7));
      wr_en = ($urandom_range(0, 2) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      wdata = $urandom() & $urandom();
      case (sel)
        0: addr = PEND;
        1: addr = MSET;
        2, 3: addr = MCLR;
        4, 5: addr = ctl_a(int'($urandom_range(0, NP - 1)));
        6: addr = 12'h080;
        default: addr = AW'($urandom());
      endcase
    end
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule